// File: doc/BRIEF.md
# Character Display Parallel Bus Master

This block is the host side of the 8-bit parallel bus used by character dot-matrix display controllers, such as a 16 column by 2 line panel. A client hands it one access at a time through a valid/ready request port. Each access has a register select (instruction/status or data), a direction, and a write byte. The block then produces the register-select, read/write and enable strobes, and drives or samples the data lines. Read results come back as a single-cycle response pulse.

Every timing window of the bus is given in nanoseconds and converted to system clock cycles at elaboration. Each window rounds up to a whole cycle count, with a floor of one cycle. The windows are: the control setup before enable rises, the enable high time, the enable rise-to-rise period, the control/data hold after enable falls, the write data setup before enable falls, and the read access delay. After reset the block waits for a power-up interval before it accepts any request.

Two modes are chosen per request. Half-width mode splits each byte into two enable pulses on the upper four data lines, high half first. Busy polling reads the status register before the access until its top bit is clear, and publishes the controller's 7-bit address counter taken from the last status read.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset release, `req_ready_o`, `lcd_e_o` and `lcd_db_oe_o` stay low for the power-up interval (POWER_UP_NS rounded up to clock cycles). `req_ready_o` rises no more than a few cycles after that interval ends.
- R2: `lcd_rs_o` follows the request select: 1 selects the data register, 0 selects the instruction register on writes and the status register on reads. `lcd_rw_o` is 1 for a read and 0 for a write. A status read returns the busy flag in bit 7 and the address counter in bits 6:0.
- R3: Every enable pulse stays high for at least the largest of the rounded enable width, write data setup and read delay windows. With the defaults at a 10 ns clock this is 30 cycles. Rounding is ceil(ns/period), with a minimum of 1.
- R4: Two successive enable rising edges are at least the rounded cycle time apart (50 cycles with the defaults at 10 ns).
- R5: `lcd_rs_o` and `lcd_rw_o` are stable for at least the rounded setup window before enable rises (6 cycles by default). They stay stable while enable is high and for at least the rounded hold window after it falls. Write data is held over the same span.
- R6: `lcd_db_oe_o` is high only during write pulses. It is low whenever `lcd_rw_o` is 1 and before any read pulse rises.
- R7: Read data is sampled on the last enable-high cycle. It is returned on `rsp_data_o` with `rsp_valid_o` high for exactly one cycle, in the cycle in which `req_ready_o` returns.
- R8: With `nibble_mode_i` set at acceptance, each byte takes two enable pulses. The first carries bits 7:4 and the second bits 3:0, both on `lcd_db_o[7:4]`, with `lcd_db_o[3:0]` driven to 0. On reads, the first pulse supplies bits 7:4 and the second supplies bits 3:0 from `lcd_db_i[7:4]`.
- R9: With `busy_poll_i` set at acceptance, the block issues status reads (RS 0, RW 1) until bit 7 reads 0, then performs the request. `ac_o` then holds bits 6:0 of that last status read.
- R10: `req_ready_o` falls when a request is accepted and stays low until the hold window after the final enable fall has passed. It is never high while enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nibble_mode_i | input | 1 | Half-width transfers for the next accepted request |
| busy_poll_i | input | 1 | Poll busy flag before the next accepted request |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_rs_i | input | 1 | Register select, 1 data, 0 instruction/status |
| req_rd_i | input | 1 | 1 read, 0 write |
| req_data_i | input | DB_W | Write byte |
| rsp_valid_o | output | 1 | One-cycle read result strobe |
| rsp_data_o | output | DB_W | Read result |
| ac_o | output | DB_W-1 | Address counter from the last clear status poll |
| lcd_rs_o | output | 1 | Bus register select |
| lcd_rw_o | output | 1 | Bus read/write |
| lcd_e_o | output | 1 | Bus enable strobe |
| lcd_db_o | output | DB_W | Bus data out |
| lcd_db_oe_o | output | 1 | Bus data output enable |
| lcd_db_i | input | DB_W | Bus data in |

## Verification
A stuck or mis-sequenced state machine shows up as a missing or extra enable pulse. The bench counts enable pulses and status reads per access, so an error appears within the same access, one poll-read pair or nibble pair later at most. A wrong cycle counter shows up at the next enable rise or fall as a short high time, a short rise-to-rise gap, or a control change inside the setup or hold span. A capture at the wrong moment returns the complemented byte that the bench's display model drives before the read delay has elapsed, so the response in the same access is wrong. A wrong output-enable state is flagged on the first cycle in which it coincides with a read.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD
  } bus_state_e;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_pwr_wait.sv
module lcd_pwr_wait #(
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned PW = $clog2(WAIT_CYC + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt_q == PW'(WAIT_CYC - 1)) done_o <= 1'b1;
      else                            cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_nib_path.sv
module lcd_nib_path #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nib_i,
  input  logic            idx_i,
  input  logic [DB_W-1:0] wdata_i,
  input  logic            cap_i,
  input  logic [DB_W-1:0] db_i,
  output logic [DB_W-1:0] db_o,
  output logic [DB_W-1:0] rdata_o
);
  localparam int unsigned NIB = DB_W / 2;

  logic [DB_W-1:0] hi_q;
  logic [NIB-1:0]  lo_q;

  always_comb begin
    if (!nib_i)      db_o = wdata_i;
    else if (!idx_i) db_o = {wdata_i[DB_W-1:NIB], {NIB{1'b0}}};
    else             db_o = {wdata_i[NIB-1:0], {NIB{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cap_i) begin
      if (nib_i && idx_i) lo_q <= db_i[DB_W-1:NIB];
      else                hi_q <= db_i;
    end
  end

  assign rdata_o = nib_i ? {hi_q[DB_W-1:NIB], lo_q} : hi_q;

endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_bus_pkg::*;
#(
  parameter int unsigned DB_W   = 8,
  parameter int unsigned SU_CYC = 1,
  parameter int unsigned HI_CYC = 1,
  parameter int unsigned HD_CYC = 1,
  parameter int unsigned CY_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_done_i,
  input  logic              nibble_mode_i,
  input  logic              busy_poll_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_rs_i,
  input  logic              req_rd_i,
  input  logic [DB_W-1:0]   req_data_i,
  input  logic [DB_W-1:0]   rdata_i,
  output logic              cap_o,
  output logic              idx_o,
  output logic              nib_o,
  output logic [DB_W-1:0]   wdata_o,
  output logic              bus_rs_o,
  output logic              bus_rw_o,
  output logic              bus_e_o,
  output logic              bus_oe_o,
  output logic              rsp_valid_o,
  output logic [DB_W-1:0]   rsp_data_o,
  output logic [DB_W-2:0]   ac_o
);
  localparam int unsigned CMAX = max_u(max_u(SU_CYC, HI_CYC), HD_CYC);
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned GW   = $clog2(CY_CYC + 1);
  localparam logic [CW-1:0] SU_LD = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] HI_LD = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] HD_LD = CW'(HD_CYC - 1);
  localparam logic [GW-1:0] G_MAX = GW'(CY_CYC - 1);

  bus_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic [GW-1:0]   gap_q;
  logic            poll_q, idx_q, nib_q, rs_q, rw_q;
  logic [DB_W-1:0] wd_q;
  logic            gap_ok, rise_go, active;

  assign gap_ok  = (gap_q >= G_MAX);
  assign rise_go = (state_q == ST_SETUP) && (cnt_q == '0) && gap_ok;
  assign active  = (state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_HOLD);

  assign req_ready_o = (state_q == ST_IDLE);
  assign bus_rs_o    = poll_q ? 1'b0 : rs_q;
  assign bus_rw_o    = poll_q ? 1'b1 : rw_q;
  assign bus_e_o     = (state_q == ST_HIGH);
  assign bus_oe_o    = active && !bus_rw_o;
  assign cap_o       = (state_q == ST_HIGH) && (cnt_q == '0) && bus_rw_o;
  assign idx_o       = idx_q;
  assign nib_o       = nib_q;
  assign wdata_o     = wd_q;

  // cycles since the last enable rise, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= G_MAX;
    else if (rise_go)       gap_q <= '0;
    else if (gap_q != G_MAX) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_WAIT;
      cnt_q       <= '0;
      poll_q      <= 1'b0;
      idx_q       <= 1'b0;
      nib_q       <= 1'b0;
      rs_q        <= 1'b0;
      rw_q        <= 1'b1;
      wd_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      ac_o        <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_WAIT: if (pwr_done_i) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (req_valid_i) begin
            rs_q    <= req_rs_i;
            rw_q    <= req_rd_i;
            wd_q    <= req_data_i;
            nib_q   <= nibble_mode_i;
            poll_q  <= busy_poll_i;
            idx_q   <= 1'b0;
            cnt_q   <= SU_LD;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (gap_ok) begin
            cnt_q   <= HI_LD;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else begin
            cnt_q   <= HD_LD;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (nib_q && !idx_q) begin
            idx_q   <= 1'b1;
            cnt_q   <= SU_LD;
            state_q <= ST_SETUP;
          end else if (poll_q) begin
            idx_q   <= 1'b0;
            cnt_q   <= SU_LD;
            state_q <= ST_SETUP;
            if (!rdata_i[DB_W-1]) begin
              poll_q <= 1'b0;
              ac_o   <= rdata_i[DB_W-2:0];
            end
          end else begin
            state_q <= ST_IDLE;
            if (rw_q) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= rdata_i;
            end
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  p_oe_write_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_e_o) && bus_rw_o) |-> ($past(!bus_oe_o) && !bus_oe_o));

  p_rsp_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_ready_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!bus_e_o && !bus_oe_o));

endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lcd_bus_pkg::*;
#(
  parameter int unsigned DB_W          = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_SETUP_NS    = 60,
  parameter int unsigned T_PULSE_NS    = 300,
  parameter int unsigned T_CYCLE_NS    = 500,
  parameter int unsigned T_HOLD_NS     = 10,
  parameter int unsigned T_WDSU_NS     = 100,
  parameter int unsigned T_RDDLY_NS    = 190,
  parameter int unsigned POWER_UP_NS   = 50_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nibble_mode_i,
  input  logic            busy_poll_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_rs_i,
  input  logic            req_rd_i,
  input  logic [DB_W-1:0] req_data_i,
  output logic            rsp_valid_o,
  output logic [DB_W-1:0] rsp_data_o,
  output logic [DB_W-2:0] ac_o,
  output logic            lcd_rs_o,
  output logic            lcd_rw_o,
  output logic            lcd_e_o,
  output logic [DB_W-1:0] lcd_db_o,
  output logic            lcd_db_oe_o,
  input  logic [DB_W-1:0] lcd_db_i
);
  localparam int unsigned SU_CYC  = ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned HI_CYC  = max_u(max_u(ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_WDSU_NS, CLK_PERIOD_NS)),
                                          ns_to_cyc(T_RDDLY_NS, CLK_PERIOD_NS));
  localparam int unsigned HD_CYC  = ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned CY_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned PWR_CYC = ns_to_cyc(POWER_UP_NS, CLK_PERIOD_NS);

  logic            pwr_done, cap, idx, nib;
  logic [DB_W-1:0] wdata, rdata;

  lcd_pwr_wait #(.WAIT_CYC(PWR_CYC)) i_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pwr_done)
  );

  lcd_bus_seq #(
    .DB_W   (DB_W),
    .SU_CYC (SU_CYC),
    .HI_CYC (HI_CYC),
    .HD_CYC (HD_CYC),
    .CY_CYC (CY_CYC)
  ) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_done_i    (pwr_done),
    .nibble_mode_i (nibble_mode_i),
    .busy_poll_i   (busy_poll_i),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_rs_i      (req_rs_i),
    .req_rd_i      (req_rd_i),
    .req_data_i    (req_data_i),
    .rdata_i       (rdata),
    .cap_o         (cap),
    .idx_o         (idx),
    .nib_o         (nib),
    .wdata_o       (wdata),
    .bus_rs_o      (lcd_rs_o),
    .bus_rw_o      (lcd_rw_o),
    .bus_e_o       (lcd_e_o),
    .bus_oe_o      (lcd_db_oe_o),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o),
    .ac_o          (ac_o)
  );

  lcd_nib_path #(.DB_W(DB_W)) i_path (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nib_i   (nib),
    .idx_i   (idx),
    .wdata_i (wdata),
    .cap_i   (cap),
    .db_i    (lcd_db_i),
    .db_o    (lcd_db_o),
    .rdata_o (rdata)
  );

  // checker counters: enable high run length and rise-to-rise distance
  localparam int unsigned EW = $clog2(HI_CYC + 1);
  localparam int unsigned RW = $clog2(CY_CYC + 1);
  logic [EW-1:0] e_run_q;
  logic [RW-1:0] rr_q;
  logic          e_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_run_q <= '0;
      rr_q    <= RW'(CY_CYC);
      e_q     <= 1'b0;
    end else begin
      e_q <= lcd_e_o;
      if (!lcd_e_o)                        e_run_q <= '0;
      else if (e_run_q != EW'(HI_CYC))     e_run_q <= e_run_q + 1'b1;
      if (lcd_e_o && !e_q)                 rr_q <= RW'(1);
      else if (rr_q != RW'(CY_CYC))        rr_q <= rr_q + 1'b1;
    end
  end

  p_wait_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done |-> (!lcd_e_o && !req_ready_o && !lcd_db_oe_o));

  p_pulse_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcd_e_o && e_q) |-> (e_run_q >= EW'(HI_CYC)));

  p_rise_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && !e_q) |-> (rr_q >= RW'(CY_CYC)));

  p_ctrl_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_e_o |-> ($stable(lcd_rs_o) && $stable(lcd_rw_o)));

  p_ctrl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcd_e_o && e_q) |-> ($stable(lcd_rs_o) && $stable(lcd_rw_o) &&
                           (lcd_rw_o || $stable(lcd_db_o))));

endmodule

// File: tb/test_lcd_bus_master.sv
module test_lcd_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int PWR_NS  = 2000;
  localparam int PWR_CYC = 200;
  localparam int SU  = 6;
  localparam int HI  = 30;
  localparam int HD  = 1;
  localparam int CY  = 50;
  localparam int RDC = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nib_mode = 1'b0, poll_en = 1'b0;
  logic       req_valid = 1'b0, req_rs = 1'b0, req_rd = 1'b0;
  logic [7:0] req_data = '0;
  logic       req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [6:0] ac;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_oe;
  logic [7:0] lcd_dbo;
  logic [7:0] lcd_dbi = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_bus_master #(.CLK_PERIOD_NS(CLK_PERIOD), .POWER_UP_NS(PWR_NS)) i_lcd_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .nibble_mode_i(nib_mode), .busy_poll_i(poll_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_rs_i(req_rs), .req_rd_i(req_rd),
    .req_data_i(req_data), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .ac_o(ac),
    .lcd_rs_o(lcd_rs), .lcd_rw_o(lcd_rw), .lcd_e_o(lcd_e), .lcd_db_o(lcd_dbo),
    .lcd_db_oe_o(lcd_oe), .lcd_db_i(lcd_dbi)
  );

  int n_chk = 0, n_fail = 0;

  // display model configuration, written by tasks only
  int         epoch = 0, busy_cfg = 0;
  logic       tb_nib = 1'b0;
  logic [6:0] ac_val = '0;
  logic [7:0] rd_val = '0;

  // display model state, written by the monitor only
  int   epoch_seen = 0, busy_left = 0, stat_reads = 0, pulses = 0;
  int   stable_run = 0, fall_age = 1000, rr = 1000, hcnt = 0;
  int   v_width = 0, v_cycle = 0, v_setup = 0, v_hold = 0, v_oe = 0, v_nib = 0;
  int   v_rsp = 0, v_ready = 0, rsp_cnt = 0, ir_cnt = 0, dr_cnt = 0;
  logic e_prev = 0, rs_prev = 0, rw_prev = 1, s_rs = 0, s_rw = 0, s_idx = 0, rsp_prev = 0;
  logic [3:0] hi_nib = '0;
  logic [7:0] ir_byte = '0, dr_byte = '0, rsp_last = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic rise, fall;
      logic [7:0] b, word;
      if (epoch != epoch_seen) begin
        epoch_seen = epoch; busy_left = busy_cfg; stat_reads = 0; s_idx = 0; pulses = 0;
      end
      rise = lcd_e && !e_prev;
      fall = !lcd_e && e_prev;
      if (fall) fall_age = 0; else if (fall_age < 1000) fall_age++;
      if (rr < 1000) rr++;
      if ({lcd_rs, lcd_rw} != {rs_prev, rw_prev}) begin
        if (lcd_e) v_setup++;
        if (!lcd_e && fall_age < HD) v_hold++;
        stable_run = 1;
      end else if (stable_run < 1000) stable_run++;
      if (lcd_oe && lcd_rw) v_oe++;
      if (req_ready && lcd_e) v_ready++;
      if (rise) begin
        if (stable_run < SU + 1) v_setup++;
        if (rr < CY) v_cycle++;
        rr = 0; hcnt = 0; s_rs = lcd_rs; s_rw = lcd_rw; pulses++;
      end
      if (lcd_e) hcnt++;
      if (fall) begin
        if (hcnt < HI) v_width++;
        if (!s_rw) begin
          if (!lcd_oe) v_oe++;
          if (tb_nib && lcd_dbo[3:0] != 4'h0) v_nib++;
          if (tb_nib && !s_idx) hi_nib = lcd_dbo[7:4];
          else begin
            b = tb_nib ? {hi_nib, lcd_dbo[7:4]} : lcd_dbo;
            if (s_rs) begin dr_byte = b; dr_cnt++; end
            else      begin ir_byte = b; ir_cnt++; end
          end
        end else if ((!tb_nib || s_idx) && !s_rs) begin
          stat_reads++;
          if (busy_left > 0) busy_left--;
        end
        if (tb_nib) s_idx = ~s_idx;
      end
      if (lcd_e && s_rw) begin
        b = s_rs ? rd_val : {(busy_left != 0), ac_val};
        word = tb_nib ? {(s_idx ? b[3:0] : b[7:4]), 4'h0} : b;
        lcd_dbi = (hcnt > RDC) ? word : ~word;
      end
      if (rsp_valid) begin
        rsp_cnt++; rsp_last = rsp_data;
        if (rsp_prev) v_rsp++;
      end
      rsp_prev = rsp_valid;
      e_prev = lcd_e; rs_prev = lcd_rs; rw_prev = lcd_rw;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // one access; checks ready drops after acceptance (R10)
  task automatic do_req(input logic rs, input logic rd, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_rs = rs; req_rd = rd; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10", "ready after accept", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_mode(input logic nib, input logic poll, input int busy, input logic [6:0] a);
    @(negedge clk);
    nib_mode = nib; tb_nib = nib; poll_en = poll; busy_cfg = busy; ac_val = a;
    epoch = epoch + 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int wait_n = 0;
    int bad = 0;
    repeat (3) @(negedge clk);
    check(!req_ready && !lcd_e && !rsp_valid && !lcd_oe, "R1", "reset state",
          {req_ready, lcd_e, rsp_valid, lcd_oe}, 0);
    rst_n = 1'b1;
    while (!req_ready && wait_n < PWR_CYC + 50) begin
      @(negedge clk);
      wait_n++;
      if (lcd_e || lcd_oe) bad++;
    end
    check(wait_n >= PWR_CYC && wait_n <= PWR_CYC + 4, "R1", "power-up wait", wait_n, PWR_CYC);
    check(bad == 0, "R1", "bus quiet during wait", bad, 0);
  endtask

  task automatic t_write8();
    set_mode(0, 0, 0, 7'h00);
    do_req(1'b0, 1'b0, 8'h38);
    check(ir_byte == 8'h38 && ir_cnt == 1, "R2", "instruction write", ir_byte, 8'h38);
    do_req(1'b1, 1'b0, 8'h4B);
    check(dr_byte == 8'h4B && dr_cnt == 1, "R2", "data write", dr_byte, 8'h4B);
    check(pulses == 2, "R2", "one pulse per byte", pulses, 2);
  endtask

  task automatic t_read8();
    int c0;
    set_mode(0, 0, 0, 7'h25);
    rd_val = 8'hC3;
    c0 = rsp_cnt;
    do_req(1'b1, 1'b1, 8'h00);
    check(rsp_cnt == c0 + 1 && rsp_last == 8'hC3, "R7", "data read", rsp_last, 8'hC3);
    do_req(1'b0, 1'b1, 8'h00);
    check(rsp_last == 8'h25, "R2", "status read idle", rsp_last, 8'h25);
    set_mode(0, 0, 1, 7'h25);
    do_req(1'b0, 1'b1, 8'h00);
    check(rsp_last == 8'hA5, "R2", "status read busy bit", rsp_last, 8'hA5);
  endtask

  task automatic t_nibble();
    set_mode(1, 0, 0, 7'h00);
    do_req(1'b1, 1'b0, 8'h9E);
    check(dr_byte == 8'h9E, "R8", "nibble write byte", dr_byte, 8'h9E);
    check(pulses == 2, "R8", "nibble write pulses", pulses, 2);
    check(v_nib == 0, "R8", "low lines zero", v_nib, 0);
    rd_val = 8'h71;
    do_req(1'b1, 1'b1, 8'h00);
    check(rsp_last == 8'h71 && pulses == 4, "R8", "nibble read", rsp_last, 8'h71);
  endtask

  task automatic t_poll8();
    set_mode(0, 1, 3, 7'h11);
    do_req(1'b1, 1'b0, 8'h55);
    check(stat_reads == 4, "R9", "status polls", stat_reads, 4);
    check(dr_byte == 8'h55 && pulses == 5, "R9", "write after poll", dr_byte, 8'h55);
    check(ac == 7'h11, "R9", "address counter", ac, 7'h11);
  endtask

  task automatic t_poll_nib();
    set_mode(1, 1, 2, 7'h6A);
    rd_val = 8'h3C;
    do_req(1'b1, 1'b1, 8'h00);
    check(stat_reads == 3 && pulses == 8, "R9", "nibble polls", stat_reads, 3);
    check(rsp_last == 8'h3C, "R8", "read after nibble poll", rsp_last, 8'h3C);
    check(ac == 7'h6A, "R9", "nibble address counter", ac, 7'h6A);
  endtask

  task automatic t_timing();
    set_mode(0, 0, 0, 7'h00);
    do_req(1'b0, 1'b0, 8'h01);
    do_req(1'b0, 1'b1, 8'h00);
    do_req(1'b1, 1'b0, 8'hE7);
    check(v_width == 0, "R3", "enable width", v_width, 0);
    check(v_cycle == 0, "R4", "rise to rise", v_cycle, 0);
    check(v_setup == 0, "R5", "control setup", v_setup, 0);
    check(v_hold == 0, "R5", "control hold", v_hold, 0);
    check(v_oe == 0, "R6", "output enable", v_oe, 0);
    check(v_rsp == 0, "R7", "response pulse width", v_rsp, 0);
    check(v_ready == 0, "R10", "ready while enable high", v_ready, 0);
  endtask

  initial begin
    t_reset();
    t_write8();
    t_read8();
    t_nibble();
    t_poll8();
    t_poll_nib();
    t_timing();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    summary();
    $finish;
  end

endmodule